// File: doc/BRIEF.md
# Macro Sequencer with Delay Slots

This block steps a command-macro processor through its program. It keeps the instruction pointer, presents fetch addresses to a synchronous instruction RAM, and decides which instruction runs next. Conditional relative branches test one register for zero or non-zero. Each branch carries its own bit that selects whether the following instruction runs as a delay slot before control moves. An end flag stops the macro after one trailing instruction. The block also owns the pop side of the parameter FIFO. It loads register 1 from the FIFO before the first instruction and supplies parameters to instructions that consume one. The ALU and the emit datapath sit outside and take their cues from the strobes this block produces.

A macro begins with a one-cycle `start` pulse while the sequencer is idle. The sequencer first loads register 1 and then retires at most one instruction per cycle. It pauses only when an instruction needs a parameter, the FIFO is empty and more input may still arrive. Once the trailing instruction has retired, `done` pulses for one cycle and the sequencer returns to idle.

Top module: `macro_seq_core`

## Requirements
- R1: After `start` is accepted in idle, `r1_load` asserts exactly once with `param_data` equal to the FIFO head, or 0 when the FIFO is empty and `input_closed` is high. This happens before any `exec_valid`, and the first instruction to retire has `exec_ip` equal to 0.
- R2: A branch (word bit 0 set) tests the register selected by bits 7:5, driven on `src_sel`. With bit 1 clear it is taken when the value is zero; with bit 1 set it is taken when the value is non-zero. Register index 0 always reads as zero, whatever `src_val` holds.
- R3: A taken branch goes to its own address plus the sign-extended 18-bit immediate in bits 25:8, modulo 2^IP_W.
- R4: A branch with bit 2 clear is delayed: the instruction after it retires next. The target follows if the branch was taken; otherwise the instruction after the delay slot follows.
- R5: A branch with bit 2 set moves control at once: the next instruction to retire is the target if taken, or the following address if not.
- R6: An instruction whose end flag (bit 3) is set, and which is not a delayed branch, is followed by exactly one more retired instruction. Then the run ends.
- R7: An end flag on a delayed branch has no effect. The end flag of that branch's delay slot is also ignored, and execution continues.
- R8: A branch that sits in a delay slot is not evaluated. Control after the slot follows only the branch that created the slot.
- R9: An instruction with bit 4 set consumes one parameter. If the FIFO is empty and `input_closed` is low, nothing retires and nothing pops until data arrives. If `input_closed` is high, the instruction retires with `param_data` equal to 0. The preload of R1 obeys the same rule.
- R10: While no parameter stall occurs, instructions retire on consecutive cycles.
- R11: `done` is high for exactly one cycle, in the cycle after the trailing instruction retires. A `start` pulse while a macro is running is ignored.
- R12: `fifo_pop` asserts only when the FIFO is non-empty, and only for the preload or for a retiring instruction that consumes a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a macro (accepted in idle only) |
| imem_addr | output | IP_W | Instruction RAM read address; data returns one cycle later |
| imem_rdata | input | 32 | Instruction word for the previous cycle's address |
| src_sel | output | 3 | Register index tested by a branch |
| src_val | input | DATA_W | Value of register `src_sel` |
| fifo_empty | input | 1 | Parameter FIFO holds no data |
| fifo_data | input | DATA_W | Parameter FIFO head |
| input_closed | input | 1 | No further parameters will arrive |
| fifo_pop | output | 1 | Remove the FIFO head at this clock edge |
| param_data | output | DATA_W | Parameter for the preload or the retiring instruction (0 when empty) |
| r1_load | output | 1 | Write `param_data` into register 1 |
| exec_valid | output | 1 | The instruction in `imem_rdata` retires this cycle |
| exec_ip | output | IP_W | Address of the current instruction |
| done | output | 1 | One-cycle end-of-macro pulse |

## Verification
The bench builds the sequencer with IP_W = 6, so the program space is 64 words. Small immediates can then push a branch target past either end of the address range, which exercises the modulo arithmetic of R3. With only 64 words, random programs also hit delay slots and end-flag combinations densely. DATA_W stays at 32, so register values near zero and large values both occur. Directed programs with hand-written retire sequences cover the delay-slot and end-flag corners. Separate directed runs cover the parameter stall and closed-input cases.

// File: rtl/macro_seq_pkg.sv
`timescale 1ns/1ps
package macro_seq_pkg;
  localparam int INST_W    = 32;
  localparam int IMM_W     = 18;
  localparam int REG_IDX_W = 3;

  // Instruction word bit positions
  localparam int B_BR     = 0;
  localparam int B_NZ     = 1;
  localparam int B_ND     = 2;
  localparam int B_END    = 3;
  localparam int B_PAR    = 4;
  localparam int F_SRC_LO = 5;
  localparam int F_IMM_LO = F_SRC_LO + REG_IDX_W;
  localparam int F_TOP    = F_IMM_LO + IMM_W;

  typedef struct packed {
    logic                 is_br;
    logic                 test_nz;
    logic                 no_delay;
    logic                 end_f;
    logic                 use_par;
    logic [REG_IDX_W-1:0] src;
    logic [IMM_W-1:0]     imm;
  } inst_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } st_t;
endpackage

// File: rtl/macro_seq_decode.sv
`timescale 1ns/1ps
module macro_seq_decode
  import macro_seq_pkg::*;
(
  input  logic [INST_W-1:0] word,
  output inst_t             fields
);
  logic unused_hi;

  always_comb begin
    fields.is_br    = word[B_BR];
    fields.test_nz  = word[B_NZ];
    fields.no_delay = word[B_ND];
    fields.end_f    = word[B_END];
    fields.use_par  = word[B_PAR];
    fields.src      = word[F_SRC_LO +: REG_IDX_W];
    fields.imm      = word[F_IMM_LO +: IMM_W];
  end

  assign unused_hi = ^word[INST_W-1:F_TOP];
endmodule

// File: rtl/macro_seq_branch.sv
`timescale 1ns/1ps
module macro_seq_branch
  import macro_seq_pkg::*;
#(
  parameter int IP_W   = 12,
  parameter int DATA_W = 32
) (
  input  logic                 eval_en,
  input  logic [IP_W-1:0]      ip,
  input  inst_t                inst,
  input  logic [DATA_W-1:0]    src_val,
  output logic [REG_IDX_W-1:0] src_sel,
  output logic                 taken,
  output logic [IP_W-1:0]      target
);
  logic            is_zero;
  logic [IP_W-1:0] offs;

  assign src_sel = inst.src;
  // Register index 0 is hard-wired zero
  assign is_zero = (inst.src == '0) || (src_val == '0);
  assign taken   = eval_en && inst.is_br && (inst.test_nz ? !is_zero : is_zero);

  generate
    if (IP_W < IMM_W) begin : g_trunc
      logic unused_imm_hi;
      assign unused_imm_hi = ^inst.imm[IMM_W-1:IP_W];
      assign offs = inst.imm[IP_W-1:0];
    end else if (IP_W == IMM_W) begin : g_same
      assign offs = inst.imm;
    end else begin : g_ext
      assign offs = {{(IP_W-IMM_W){inst.imm[IMM_W-1]}}, inst.imm};
    end
  endgenerate

  assign target = ip + offs;
endmodule

// File: rtl/macro_seq_param.sv
`timescale 1ns/1ps
module macro_seq_param #(
  parameter int DATA_W = 32
) (
  input  logic              want,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              input_closed,
  output logic              stall,
  output logic              pop,
  output logic [DATA_W-1:0] value
);
  assign stall = want && fifo_empty && !input_closed;
  assign pop   = want && !fifo_empty;
  assign value = fifo_empty ? '0 : fifo_data;
endmodule

// File: rtl/macro_seq_core.sv
`timescale 1ns/1ps
module macro_seq_core
  import macro_seq_pkg::*;
#(
  parameter int IP_W   = 12,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic [IP_W-1:0]      imem_addr,
  input  logic [INST_W-1:0]    imem_rdata,
  output logic [REG_IDX_W-1:0] src_sel,
  input  logic [DATA_W-1:0]    src_val,
  input  logic                 fifo_empty,
  input  logic [DATA_W-1:0]    fifo_data,
  input  logic                 input_closed,
  output logic                 fifo_pop,
  output logic [DATA_W-1:0]    param_data,
  output logic                 r1_load,
  output logic                 exec_valid,
  output logic [IP_W-1:0]      exec_ip,
  output logic                 done
);
  localparam logic [IP_W-1:0] IP_ONE = IP_W'(1);

  st_t             st_q, st_d;
  logic [IP_W-1:0] ip_q, ip_d;
  logic            slot_q, slot_d;      // current instruction is a delay slot
  logic            sl_tk_q, sl_tk_d;    // branch owning the slot was taken
  logic [IP_W-1:0] sl_tgt_q, sl_tgt_d;  // its target
  logic            mute_q, mute_d;      // slot end flag suppressed
  logic            last_q, last_d;      // current instruction is the trailing one

  inst_t           cur;
  logic            in_run, in_load, want, stall, adv;
  logic            eval_en, br_taken, delayed, ctl_en;
  logic [IP_W-1:0] br_tgt, seq_ip, next_ip;

  macro_seq_decode u_dec (
    .word   (imem_rdata),
    .fields (cur)
  );

  assign in_run  = (st_q == ST_RUN);
  assign in_load = (st_q == ST_LOAD);
  assign want    = in_load || (in_run && cur.use_par);

  macro_seq_param #(.DATA_W(DATA_W)) u_par (
    .want         (want),
    .fifo_empty   (fifo_empty),
    .fifo_data    (fifo_data),
    .input_closed (input_closed),
    .stall        (stall),
    .pop          (fifo_pop),
    .value        (param_data)
  );

  assign adv     = !stall;
  assign eval_en = in_run && !slot_q && !last_q;

  macro_seq_branch #(.IP_W(IP_W), .DATA_W(DATA_W)) u_br (
    .eval_en (eval_en),
    .ip      (ip_q),
    .inst    (cur),
    .src_val (src_val),
    .src_sel (src_sel),
    .taken   (br_taken),
    .target  (br_tgt)
  );

  assign delayed = eval_en && cur.is_br && !cur.no_delay;
  assign seq_ip  = ip_q + IP_ONE;

  always_comb begin
    if (slot_q) begin
      next_ip = sl_tk_q ? sl_tgt_q : seq_ip;
    end else if (br_taken && !delayed) begin
      next_ip = br_tgt;
    end else begin
      next_ip = seq_ip;
    end
  end

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    ip_d     = ip_q;
    slot_d   = slot_q;
    sl_tk_d  = sl_tk_q;
    sl_tgt_d = sl_tgt_q;
    mute_d   = mute_q;
    last_d   = last_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_LOAD;
          ip_d    = '0;
          slot_d  = 1'b0;
          sl_tk_d = 1'b0;
          mute_d  = 1'b0;
          last_d  = 1'b0;
        end
      end
      ST_LOAD: begin
        if (adv) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (adv) begin
          if (last_q) begin
            st_d   = ST_DONE;
            last_d = 1'b0;
            slot_d = 1'b0;
            mute_d = 1'b0;
          end else begin
            ip_d     = next_ip;
            slot_d   = delayed;
            sl_tk_d  = br_taken;
            sl_tgt_d = br_tgt;
            mute_d   = delayed && cur.end_f;
            last_d   = cur.end_f && !delayed && !mute_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ctl_en = ((st_q == ST_IDLE) && start) || (in_run && adv);

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // Control registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q     <= '0;
      slot_q   <= 1'b0;
      sl_tk_q  <= 1'b0;
      sl_tgt_q <= '0;
      mute_q   <= 1'b0;
      last_q   <= 1'b0;
    end else if (ctl_en) begin
      ip_q     <= ip_d;
      slot_q   <= slot_d;
      sl_tk_q  <= sl_tk_d;
      sl_tgt_q <= sl_tgt_d;
      mute_q   <= mute_d;
      last_q   <= last_d;
    end
  end

  // Fetch: next address when retiring, same address while stalled
  always_comb begin
    if (in_run) begin
      imem_addr = adv ? next_ip : ip_q;
    end else begin
      imem_addr = '0;
    end
  end

  assign exec_valid = in_run && adv;
  assign r1_load    = in_load && adv;
  assign exec_ip    = ip_q;
  assign done       = (st_q == ST_DONE);
endmodule

// File: rtl/macro_seq_core_chk.sv
`timescale 1ns/1ps
module macro_seq_core_chk #(
  parameter int IP_W   = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_pop,
  input logic              fifo_empty,
  input logic              input_closed,
  input logic [DATA_W-1:0] param_data,
  input logic              r1_load,
  input logic              exec_valid,
  input logic [IP_W-1:0]   exec_ip,
  input logic              done,
  input logic              inst_par
);
  logic loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
    end else if (r1_load) begin
      loaded_q <= 1'b1;
    end else if (done) begin
      loaded_q <= 1'b0;
    end
  end

  p_exec_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> loaded_q);

  p_first_ip_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    r1_load |=> (exec_ip == '0));

  p_closed_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && inst_par && fifo_empty) |-> (input_closed && param_data == '0));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_exec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(exec_valid));

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!exec_valid && !r1_load));

  p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  p_pop_for_user_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (r1_load || (exec_valid && inst_par)));
endmodule

bind macro_seq_core macro_seq_core_chk #(.IP_W(IP_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_pop     (fifo_pop),
  .fifo_empty   (fifo_empty),
  .input_closed (input_closed),
  .param_data   (param_data),
  .r1_load      (r1_load),
  .exec_valid   (exec_valid),
  .exec_ip      (exec_ip),
  .done         (done),
  .inst_par     (imem_rdata[macro_seq_pkg::B_PAR])
);

// File: tb/tb_macro_seq_core.sv
`timescale 1ns/1ps
module tb_macro_seq_core;
  localparam int IP_W   = 6;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1 << IP_W;
  localparam int MAXS   = 150;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, start, input_closed, fifo_clr;
  logic [IP_W-1:0]   imem_addr, exec_ip;
  logic [31:0]       imem_rdata;
  logic [2:0]        src_sel;
  logic [DATA_W-1:0] src_val, fifo_data, param_data;
  logic              fifo_empty, fifo_pop, r1_load, exec_valid, done;

  logic [31:0]       prog [DEPTH];
  logic [DATA_W-1:0] bank [8];
  logic [DATA_W-1:0] fq [256];
  int fifo_rd, fifo_wr;
  int exp_ip [256];
  int exp_n;
  int checks = 0, fails = 0;
  bit finished = 0;

  macro_seq_core #(.IP_W(IP_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .src_sel(src_sel), .src_val(src_val),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .input_closed(input_closed),
    .fifo_pop(fifo_pop), .param_data(param_data), .r1_load(r1_load),
    .exec_valid(exec_valid), .exec_ip(exec_ip), .done(done)
  );

  always_ff @(posedge clk) imem_rdata <= prog[imem_addr];
  always_ff @(posedge clk) begin
    if (fifo_clr) fifo_rd <= 0;
    else if (fifo_pop) fifo_rd <= fifo_rd + 1;
  end
  assign fifo_empty = (fifo_rd >= fifo_wr);
  assign fifo_data  = fq[fifo_rd & 255];
  always_comb src_val = bank[src_sel];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] enc(input bit br, input bit nz, input bit nd,
                                      input bit en, input bit up, input int src, input int imm);
    logic [17:0] i18;
    logic [2:0]  s3;
    i18 = 18'(imm);
    s3  = 3'(src);
    return {6'b0, i18, s3, up, en, nd, nz, br};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'h0;
  endtask

  task automatic set_fifo(input int cnt, input bit closed);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    for (int i = 0; i < 256; i++) fq[i] = DATA_W'($urandom) | 32'h1;
    fifo_wr = cnt;
    input_closed = closed;
  endtask

  // Reference sequencing from the requirements; returns -1 if no end is reached
  task automatic model(output int n);
    int ip, stgt, src, nxt;
    bit slot, stk, mute, last, br, nz, nd, en, taken, dly, zero;
    logic [31:0] w;
    ip = 0; stgt = 0; slot = 0; stk = 0; mute = 0; last = 0; n = 0;
    while (n < MAXS) begin
      exp_ip[n] = ip;
      n++;
      w = prog[ip];
      if (last) return;
      br = w[0]; nz = w[1]; nd = w[2]; en = w[3]; src = int'(w[7:5]);
      zero  = (src == 0) || (bank[src] == 0);
      taken = br && !slot && (nz ? !zero : zero);
      dly   = br && !slot && !nd;
      if (slot) nxt = stk ? stgt : (ip + 1) % DEPTH;
      else if (taken && !dly) nxt = (ip + int'(w[8 +: IP_W])) % DEPTH;
      else nxt = (ip + 1) % DEPTH;
      last = en && !dly && !mute;
      mute = dly && en;
      stk  = taken;
      stgt = (ip + int'(w[8 +: IP_W])) % DEPTH;
      slot = dly;
      ip   = nxt;
    end
    n = -1;
  endtask

  task automatic run_prog(input string req, input bit no_stall, input bit poke);
    int cyc, m, k, first_c, last_c;
    bit seen_load;
    longint ev;
    m = 0; k = 0; cyc = 0; first_c = -1; last_c = -1; seen_load = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      #1;
      if (fifo_pop) chk(!fifo_empty, "R12", "pop while empty", fifo_empty, 0);
      if (r1_load) begin
        ev = (k < fifo_wr) ? longint'(fq[k]) : 0;
        chk(!seen_load && param_data == DATA_W'(ev), "R1", "preload value", param_data, ev);
        seen_load = 1; k++;
      end
      if (exec_valid) begin
        chk(seen_load, "R1", "retire before preload", 0, 1);
        if (m < exp_n) chk(int'(exec_ip) == exp_ip[m], req, $sformatf("retire #%0d ip", m), exec_ip, exp_ip[m]);
        else chk(0, req, "extra retire ip", exec_ip, -1);
        if (prog[exec_ip][4]) begin
          ev = (k < fifo_wr) ? longint'(fq[k]) : 0;
          chk(param_data == DATA_W'(ev), "R9", "parameter value", param_data, ev);
          k++;
        end
        if (first_c < 0) first_c = cyc;
        last_c = cyc; m++;
        if (poke && m == 2) start = 1'b1;
      end else if (poke) start = 1'b0;
      if (done) begin
        chk(m == exp_n, req, "retire count at end", m, exp_n);
        chk(last_c == cyc - 1, "R11", "done follows last retire", last_c, cyc - 1);
        if (no_stall) chk(last_c - first_c + 1 == exp_n, "R10", "cycles from first to last retire", last_c - first_c + 1, exp_n);
        start = 1'b0;
        @(negedge clk); #1;
        chk(!done, "R11", "done width", done, 0);
        chk(fifo_rd == ((k < fifo_wr) ? k : fifo_wr), "R12", "pops taken", fifo_rd, (k < fifo_wr) ? k : fifo_wr);
        break;
      end
      cyc++;
      if (cyc > 400) begin
        chk(0, req, "run timeout", cyc, exp_n);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic set_exp(input int a0, input int a1, input int a2, input int a3,
                         input int a4, input int a5, input int n);
    exp_ip[0] = a0; exp_ip[1] = a1; exp_ip[2] = a2;
    exp_ip[3] = a3; exp_ip[4] = a4; exp_ip[5] = a5; exp_n = n;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; input_closed = 1'b1; fifo_clr = 1'b1; fifo_wr = 0;
    clear_prog();
    for (int i = 0; i < 8; i++) bank[i] = '0;
    bank[0] = 32'hDEAD_0001;  // R2: index 0 must still read zero
    bank[2] = 32'h5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; fifo_clr = 1'b0;
    #1;
    chk(!done && !exec_valid && !fifo_pop && !r1_load, "R11", "reset outputs quiet", done, 0);
    chk(imem_addr == '0, "R1", "reset fetch address", imem_addr, 0);

    // R5 R3: no-delay forward branch on reg 0 tested for zero
    clear_prog();
    prog[1] = enc(1, 0, 1, 0, 0, 0, 3);
    prog[4] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 1, 4, 5, 0, 0, 4);
    run_prog("R5", 1, 0);

    // R4: delayed taken branch
    clear_prog();
    prog[0] = enc(1, 0, 0, 0, 0, 0, 5);
    prog[5] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 1, 5, 6, 0, 0, 4);
    run_prog("R4", 1, 0);

    // R7: end on delayed branch and on its slot both ignored
    clear_prog();
    prog[1] = enc(1, 0, 0, 1, 0, 0, 3);
    prog[2] = enc(0, 0, 0, 1, 0, 0, 0);
    prog[5] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 1, 2, 4, 5, 6, 6);
    run_prog("R7", 1, 0);

    // R8: branch inside a delay slot is not evaluated
    clear_prog();
    prog[0] = enc(1, 0, 0, 0, 0, 0, 4);
    prog[1] = enc(1, 0, 1, 0, 0, 0, 10);
    prog[4] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 1, 4, 5, 0, 0, 4);
    run_prog("R8", 1, 0);

    // R2: reg 2 = 5, zero-test not taken, then non-zero test taken
    clear_prog();
    prog[0] = enc(1, 0, 1, 0, 0, 2, 9);
    prog[1] = enc(1, 1, 1, 0, 0, 2, 6);
    prog[7] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 1, 7, 8, 0, 0, 4);
    run_prog("R2", 1, 0);

    // R3: backward branch wraps modulo 64
    clear_prog();
    prog[0] = enc(1, 0, 1, 0, 0, 0, -2);
    prog[62] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 62, 63, 0, 0, 0, 3);
    run_prog("R3", 1, 0);

    // R6: end on a taken no-delay branch; the target is the trailing one
    clear_prog();
    prog[0] = enc(1, 0, 1, 1, 0, 0, 7);
    set_fifo(4, 0); set_exp(0, 7, 0, 0, 0, 0, 2);
    run_prog("R6", 1, 0);

    // R11: start pulse mid-run is ignored
    clear_prog();
    prog[0] = enc(1, 0, 0, 0, 0, 0, 5);
    prog[5] = enc(0, 0, 0, 1, 0, 0, 0);
    set_fifo(4, 0); set_exp(0, 1, 5, 6, 0, 0, 4);
    run_prog("R11", 1, 1);

    // R9: closed empty FIFO gives zeros
    clear_prog();
    prog[0] = enc(0, 0, 0, 0, 1, 0, 0);
    prog[1] = enc(0, 0, 0, 1, 1, 0, 0);
    set_fifo(0, 1); set_exp(0, 1, 2, 0, 0, 0, 3);
    run_prog("R9", 1, 0);

    // R9: open empty FIFO stalls preload and a consuming instruction
    clear_prog();
    prog[1] = enc(0, 0, 0, 1, 1, 0, 0);
    set_fifo(0, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk(!r1_load && !exec_valid && !fifo_pop, "R9", "preload stall", r1_load | exec_valid, 0);
      @(negedge clk);
    end
    fq[0] = 32'hA5A5_0001; fq[1] = 32'h0BEE_F002; fifo_wr = 1;
    #1;
    chk(r1_load && param_data == 32'hA5A5_0001, "R1", "preload after arrival", param_data, 32'hA5A5_0001);
    @(negedge clk); #1;
    chk(exec_valid && exec_ip == 0, "R1", "first retire ip", exec_ip, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!exec_valid && !fifo_pop && exec_ip == 1, "R9", "consumer stall", exec_valid, 0);
    end
    fifo_wr = 2; #1;
    chk(exec_valid && exec_ip == 1 && param_data == 32'h0BEE_F002, "R9", "consumer after arrival", param_data, 32'h0BEE_F002);
    @(negedge clk); #1;
    chk(exec_valid && exec_ip == 2, "R6", "trailing retire", exec_ip, 2);
    @(negedge clk); #1;
    chk(done, "R11", "done after trailing", done, 1);
    @(negedge clk);

    // Random programs checked against the reference sequencing
    for (int t = 0; t < 40; t++) begin
      int n, tries, r, imm;
      n = -1; tries = 0;
      while (n < 0 && tries < 60) begin
        for (int i = 1; i < 8; i++) bank[i] = ($urandom % 5 < 2) ? '0 : DATA_W'($urandom);
        for (int i = 0; i < DEPTH; i++) begin
          r = $urandom % 100;
          imm = ($urandom % 8 == 0) ? (int'($urandom % 141) - 70) : (int'($urandom % 21) - 10);
          prog[i] = enc(r < 28, $urandom % 2, $urandom % 2, ($urandom % 100) < 9,
                        ($urandom % 100) < 30, $urandom % 8, imm);
        end
        model(n);
        tries++;
      end
      if (n < 0) continue;
      exp_n = n;
      if (t % 3 == 0) set_fifo(3, 1);
      else set_fifo(200, $urandom % 2);
      run_prog("R2 R3 R4 R5 R6 R7 R8 random", 1, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule